// File: doc/BRIEF.md
# One-Time-Programmable ROM Mode Decoder with Identifier

This block is a synthesizable behavioural model of the control logic inside a 16-bit one-time-programmable read-only memory. It takes the active-low chip enable, output enable and program strobe pins, the word address, and two digital flags. One flag reports a high voltage on the programming supply. The other reports a high voltage on address line 9. From these it picks an operating mode and drives the data bus with a separate tristate enable. The bus carries either a stored word or one of two fixed identifier words.

In program mode, the input word is merged into the addressed location by clearing bits. A bit can go from 1 to 0 but never back. Exactly one merge happens per falling edge of the program strobe. The storage array holds `2**ARRAY_AW` words, and address bits above that width alias onto it. Reads are combinational from the pins and the array. Writes land on the rising clock edge at which the falling strobe is first seen.

Top module: `otpRomCore`

## Requirements
- R1: With chip enable low, output enable low, program strobe high and no programming voltage, dataOutEn is 1. dataOut equals the stored word at the address in the same cycle.
- R2: With output enable high, dataOutEn is 0 and dataOut reads 0, whatever the other inputs are.
- R3: With chip enable high and no programming voltage (standby), dataOutEn is 0 and dataOut reads 0.
- R4: A program operation merges dataIn into the addressed word on the first rising clock edge that samples a high-to-low strobe change. It needs chip enable low, output enable high, the strobe falling and the programming voltage present.
- R5: With chip enable low, output enable low, the strobe high and the programming voltage present (verify), the stored word is driven with dataOutEn 1.
- R6: With chip enable high and the programming voltage present (inhibit), outputs are off and a strobe falling edge changes no stored word.
- R7: Identification applies with chip enable and output enable low, address line 9 high-voltage, no programming voltage, and all address bits other than 0 and 9 low. Address bit 0 = 0 then gives 0x001E and bit 0 = 1 gives 0x00F7.
- R8: After reset every word reads 0xFFFF. Programming stores (old AND dataIn), so a second program can only clear further bits.
- R9: With address line 9 high-voltage but any address bit other than 0 and 9 set, the normal array word is returned.
- R10: Holding the strobe low for several cycles performs one write only. Later dataIn changes while it stays low have no effect.
- R11: Address bits at and above ARRAY_AW (default 8) do not affect the array location selected.
- R12: A strobe falling edge with chip enable low and output enable high but no programming voltage writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for edge detection and array writes |
| rstN | input | 1 | Active-low reset; erases the array to all ones |
| chipEnN | input | 1 | Chip enable, active low |
| outEnN | input | 1 | Output enable, active low |
| progStrobeN | input | 1 | Program strobe, active low |
| progVoltHi | input | 1 | Programming supply is at high voltage |
| a9VoltHi | input | 1 | Address line 9 is at high voltage |
| addrIn | input | 17 | Word address |
| dataIn | input | 16 | Word to program |
| dataOut | output | 16 | Read data, 0 while outputs are off |
| dataOutEn | output | 1 | Tristate enable for dataOut |

## Verification
Every read-side result (the mode, the enable and the driven word) is a function of the present pins and array contents, so it is due in the same cycle as its stimulus. The bench drives pins just after a falling clock edge and samples 1 ns later, well before the next rising edge. A write needs one rising edge after the strobe's low level appears. The bench therefore lowers the strobe at one falling edge and reads back only after the following falling edge. The held-strobe and inhibit cases keep the pins steady across several rising edges before the readback.

// File: rtl/otpRomPkg.sv
`timescale 1ns/1ps
package otpRomPkg;

  typedef enum logic [2:0] {
    MODE_STANDBY,
    MODE_INHIBIT,
    MODE_OUTOFF,
    MODE_PROGRAM,
    MODE_VERIFY,
    MODE_IDENT,
    MODE_READ
  } romModeT;

  typedef struct packed {
    logic driveOut;
    logic selIdent;
    logic writeEn;
  } romStrobeT;

  localparam logic [15:0] MAKER_WORD  = 16'h001E;
  localparam logic [15:0] DEVICE_WORD = 16'h00F7;

endpackage

// File: rtl/otpRomCtrl.sv
`timescale 1ns/1ps
module otpRomCtrl
  import otpRomPkg::*;
#(
  parameter int ADDR_W    = 17,
  parameter int IDENT_BIT = 9,
  parameter int SEL_BIT   = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chipEnN,
  input  logic              outEnN,
  input  logic              progStrobeN,
  input  logic              progVoltHi,
  input  logic              a9VoltHi,
  input  logic [ADDR_W-1:0] addrIn,
  output romStrobeT         stb
);

  localparam logic [ADDR_W-1:0] QUIET_MASK =
    ADDR_W'(~((1 << IDENT_BIT) | (1 << SEL_BIT)));

  romModeT mode;
  logic    strobePrev;
  logic    otherAddrLow;

  assign otherAddrLow = ((addrIn & QUIET_MASK) == '0);

  always_comb begin
    if (chipEnN)
      mode = progVoltHi ? MODE_INHIBIT : MODE_STANDBY;
    else if (outEnN)
      mode = (progVoltHi && !progStrobeN) ? MODE_PROGRAM : MODE_OUTOFF;
    else if (progVoltHi && progStrobeN)
      mode = MODE_VERIFY;
    else if (a9VoltHi && !progVoltHi && otherAddrLow)
      mode = MODE_IDENT;
    else
      mode = MODE_READ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) strobePrev <= 1'b1;
    else       strobePrev <= progStrobeN;
  end

  always_comb begin
    stb.driveOut = (mode == MODE_READ) || (mode == MODE_VERIFY) ||
                   (mode == MODE_IDENT);
    stb.selIdent = (mode == MODE_IDENT);
    stb.writeEn  = (mode == MODE_PROGRAM) && strobePrev;
  end

  AST_NO_WRITE_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (!rstN)
    chipEnN |-> !stb.writeEn); // R6

  AST_NO_WRITE_WITHOUT_VPP: assert property (@(posedge clk) disable iff (!rstN)
    !progVoltHi |-> !stb.writeEn); // R12

  AST_SINGLE_WRITE_PER_FALL: assert property (@(posedge clk) disable iff (!rstN)
    stb.writeEn |=> !stb.writeEn); // R10

endmodule

// File: rtl/otpRomDatapath.sv
`timescale 1ns/1ps
module otpRomDatapath
  import otpRomPkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int ARRAY_AW = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  romStrobeT           stb,
  input  logic [ARRAY_AW-1:0] arrAddr,
  input  logic                idSel,
  input  logic [DATA_W-1:0]   dataIn,
  output logic [DATA_W-1:0]   dataOut,
  output logic                dataOutEn
);

  localparam int DEPTH = 1 << ARRAY_AW;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] curWord;
  logic [DATA_W-1:0] idWord;

  assign curWord = mem[arrAddr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (stb.writeEn) begin
      mem[arrAddr] <= curWord & dataIn;
    end
  end

  assign idWord = idSel ? DATA_W'(DEVICE_WORD) : DATA_W'(MAKER_WORD);

  always_comb begin
    dataOutEn = stb.driveOut;
    if (!stb.driveOut)     dataOut = '0;
    else if (stb.selIdent) dataOut = idWord;
    else                   dataOut = curWord;
  end

  AST_CLEAR_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    stb.writeEn |=> ((mem[$past(arrAddr)] & ~$past(curWord)) == '0)); // R8

  AST_IDENT_CODES: assert property (@(posedge clk) disable iff (!rstN)
    (dataOutEn && stb.selIdent) |->
      (dataOut == DATA_W'(MAKER_WORD) || dataOut == DATA_W'(DEVICE_WORD))); // R7

  AST_QUIET_BUS: assert property (@(posedge clk) disable iff (!rstN)
    !dataOutEn |-> (dataOut == '0)); // R2

endmodule

// File: rtl/otpRomCore.sv
`timescale 1ns/1ps
module otpRomCore
  import otpRomPkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int DATA_W   = 16,
  parameter int ARRAY_AW = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chipEnN,
  input  logic              outEnN,
  input  logic              progStrobeN,
  input  logic              progVoltHi,
  input  logic              a9VoltHi,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOutEn
);

  romStrobeT stb;

  otpRomCtrl #(.ADDR_W(ADDR_W), .IDENT_BIT(9), .SEL_BIT(0)) uCtrl (
    .clk(clk), .rstN(rstN), .chipEnN(chipEnN), .outEnN(outEnN),
    .progStrobeN(progStrobeN), .progVoltHi(progVoltHi), .a9VoltHi(a9VoltHi),
    .addrIn(addrIn), .stb(stb)
  );

  otpRomDatapath #(.DATA_W(DATA_W), .ARRAY_AW(ARRAY_AW)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .arrAddr(addrIn[ARRAY_AW-1:0]),
    .idSel(addrIn[0]), .dataIn(dataIn), .dataOut(dataOut),
    .dataOutEn(dataOutEn)
  );

  AST_OUTPUT_OFF_OE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    outEnN |-> !dataOutEn); // R2

  AST_STANDBY_OFF: assert property (@(posedge clk) disable iff (!rstN)
    chipEnN |-> !dataOutEn); // R3

endmodule

// File: tb/otpRomCore_test.sv
`timescale 1ns/1ps
module otpRomCore_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        chipEnN = 1'b1, outEnN = 1'b1, progStrobeN = 1'b1;
  logic        progVoltHi = 1'b0, a9VoltHi = 1'b0;
  logic [16:0] addrIn = '0;
  logic [15:0] dataIn = '0;
  logic [15:0] dataOut;
  logic        dataOutEn;
  int          nChecks = 0;
  int          nFails = 0;

  always #2.5 clk = ~clk;

  otpRomCore uut (
    .clk(clk), .rstN(rstN), .chipEnN(chipEnN), .outEnN(outEnN),
    .progStrobeN(progStrobeN), .progVoltHi(progVoltHi), .a9VoltHi(a9VoltHi),
    .addrIn(addrIn), .dataIn(dataIn), .dataOut(dataOut), .dataOutEn(dataOutEn)
  );

  task automatic check(input string tag, input logic [16:0] act, input logic [16:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=0x%05h expected=0x%05h", tag, act, exp);
    end
  endtask

  task automatic idlePins();
    chipEnN = 1'b1; outEnN = 1'b1; progStrobeN = 1'b1;
    progVoltHi = 1'b0; a9VoltHi = 1'b0;
  endtask

  task automatic readWord(input logic [16:0] a, input string tag, input logic [15:0] exp);
    @(negedge clk);
    idlePins();
    chipEnN = 1'b0; outEnN = 1'b0; addrIn = a;
    #1;
    check(tag, {dataOutEn, dataOut}, {1'b1, exp});
  endtask

  task automatic progWord(input logic [16:0] a, input logic [15:0] d,
                          input logic ce, input logic vpp);
    @(negedge clk);
    idlePins();
    chipEnN = ce; outEnN = 1'b1; progVoltHi = vpp; addrIn = a; dataIn = d;
    @(negedge clk);
    progStrobeN = 1'b0;
    @(negedge clk);
    progStrobeN = 1'b1;
  endtask

  task automatic testReset();
    readWord(17'h00000, "R8 erased after reset", 16'hFFFF);
    readWord(17'h000FF, "R1 read top word", 16'hFFFF);
  endtask

  task automatic testOutputsOff();
    @(negedge clk);
    idlePins();
    chipEnN = 1'b0; outEnN = 1'b1; a9VoltHi = 1'b1; addrIn = 17'h00200;
    #1;
    check("R2 oe high off", {dataOutEn, dataOut}, 17'h0);
    @(negedge clk);
    idlePins();
    addrIn = 17'h00000;
    #1;
    check("R3 standby off", {dataOutEn, dataOut}, 17'h0);
  endtask

  task automatic testProgram();
    progWord(17'h00005, 16'hA5C3, 1'b0, 1'b1);
    readWord(17'h00005, "R4 programmed word", 16'hA5C3);
    progWord(17'h00005, 16'hFF0F, 1'b0, 1'b1);
    readWord(17'h00005, "R8 and merge", 16'hA503);
    progWord(17'h00005, 16'hFFFF, 1'b0, 1'b1);
    readWord(17'h00005, "R8 ones do not restore", 16'hA503);
  endtask

  task automatic testVerify();
    @(negedge clk);
    idlePins();
    chipEnN = 1'b0; outEnN = 1'b0; progVoltHi = 1'b1; addrIn = 17'h00005;
    #1;
    check("R5 verify drives word", {dataOutEn, dataOut}, {1'b1, 16'hA503});
  endtask

  task automatic testInhibit();
    @(negedge clk);
    idlePins();
    progVoltHi = 1'b1; addrIn = 17'h00006; dataIn = 16'h0000;
    @(negedge clk);
    progStrobeN = 1'b0;
    #1;
    check("R6 inhibit off", {dataOutEn, dataOut}, 17'h0);
    @(negedge clk);
    @(negedge clk);
    progStrobeN = 1'b1;
    readWord(17'h00006, "R6 inhibit no write", 16'hFFFF);
  endtask

  task automatic testNoVpp();
    progWord(17'h00007, 16'h0000, 1'b0, 1'b0);
    readWord(17'h00007, "R12 no vpp no write", 16'hFFFF);
  endtask

  task automatic testHeldStrobe();
    @(negedge clk);
    idlePins();
    chipEnN = 1'b0; progVoltHi = 1'b1; addrIn = 17'h00008; dataIn = 16'hFFF0;
    @(negedge clk);
    progStrobeN = 1'b0;
    @(negedge clk);
    dataIn = 16'h0000;
    repeat (3) @(negedge clk);
    progStrobeN = 1'b1;
    readWord(17'h00008, "R10 one write per fall", 16'hFFF0);
  endtask

  task automatic testIdent();
    @(negedge clk);
    idlePins();
    chipEnN = 1'b0; outEnN = 1'b0; a9VoltHi = 1'b1; addrIn = 17'h00200;
    #1;
    check("R7 maker word", {dataOutEn, dataOut}, {1'b1, 16'h001E});
    addrIn = 17'h00201;
    #1;
    check("R7 device word", {dataOutEn, dataOut}, {1'b1, 16'h00F7});
    addrIn = 17'h00208;
    #1;
    check("R9 other bits set gives array", {dataOutEn, dataOut}, {1'b1, 16'hFFF0});
  endtask

  task automatic testAlias();
    progWord(17'h00110, 16'h1234, 1'b0, 1'b1);
    readWord(17'h00010, "R11 upper bits ignored", 16'h1234);
    readWord(17'h1F010, "R11 alias high address", 16'h1234);
  endtask

  initial begin
    #1_000_000;
    nFails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testOutputsOff();
    testProgram();
    testVerify();
    testInhibit();
    testNoVpp();
    testHeldStrobe();
    testIdent();
    testAlias();
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule